// File: doc/BRIEF.md
# Next-Fetch-Address and Link Unit

This block owns the 32-bit program counter of a simple in-order core. It decodes the instruction word currently being executed and picks the address of the next word to fetch. That address can be the word that follows in sequence, a PC-relative target for a compare-and-branch, a region-relative jump target, or a full address taken from a register operand. For the jump-and-link instruction, the block also sends the register file a write request that carries the return address.

Each cycle the core presents the current instruction word, the two operands read at its source fields (rs and rt) and a stall flag. The PC moves once per non-stalled cycle. The link request is combinational and belongs to the instruction in the same cycle.

Top module: `npc_unit`

## Requirements
- R1: While reset is held, and until the released reset has passed through the two-stage synchroniser, `pc` reads `RESET_ADDR`. `link_we` stays low during that time.
- R2: Some words advance the PC by exactly 4. These are opcodes (bits 31..26) other than 0, 2, 3, 4 and 5, and opcode 0 with any function code (bits 5..0) other than 0x08.
- R3: Opcode 4 is branch-if-equal. When `rs_val == rt_val`, the next PC is (PC+4) plus the sign-extended bits 15..0 shifted left by 2. Otherwise the next PC is PC+4.
- R4: Opcode 5 is branch-if-unequal. It uses the same target as R3 and is taken when `rs_val != rt_val`. Otherwise the next PC is PC+4.
- R5: Opcode 2 is a jump. The next PC is bits 31..28 of PC+4, then bits 25..0 of the instruction, then two zero bits.
- R6: Opcode 3 is jump-and-link. It takes the R5 target and, in the same cycle, drives `link_we`=1, `link_addr`=`LINK_REG` (default 31) and `link_data`=PC+4.
- R7: Opcode 0 with function code 0x08 is a register jump. The next PC equals `rs_val`.
- R8: While `stall` is high, the PC keeps its value and `link_we` is low, whatever the instruction.
- R9: `link_we` is high only for opcode 3 when not stalled.
- R10: Every PC sum is taken modulo 2^32. PC+4 from 0xFFFFFFFC gives 0, and a sum that carries out of the top nibble selects the next region for R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall | input | 1 | Hold the PC and suppress the link write |
| instr | input | 32 | Instruction word being executed |
| rs_val | input | 32 | Operand read at source field rs |
| rt_val | input | 32 | Operand read at source field rt |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write enable |
| link_addr | output | 5 | Return-address destination register |
| link_data | output | 32 | Return address (PC+4) |

## Verification
The bench builds the unit with `RESET_ADDR` = 0xBFC00000. The non-zero top nibble then shows whether jumps keep the region bits of PC+4. The default `LINK_REG` of 31 is used. Every one of the 64 opcodes and every function code under opcode 0 is swept. Both branch types are run against equal and unequal operands across extreme offsets (0x7FFF, 0x8000, 0xFFFF) from several base addresses. Jumps are issued from all 16 regions. Register jumps to 0xFFFFFFFC and to a region's last word bring PC+4 wrap and region carry into reach.

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 6;
  localparam int FN_W   = 6;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int JFLD_W = 26;
  localparam int SHIFT_W = 2;
  localparam int PAGE_W = WORD_W - JFLD_W - SHIFT_W;
  localparam int SEXT_W = WORD_W - IMM_W - SHIFT_W;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JLINK   = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
  localparam logic [FN_W-1:0]  FN_REGJMP   = 6'h08;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JUMP,
    FLOW_JLINK,
    FLOW_RET
  } flow_e;
endpackage

// File: rtl/npc_rst_sync.sv
`timescale 1ns/1ps
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
  import npc_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output flow_e             flow,
  output logic [IMM_W-1:0]  imm,
  output logic [JFLD_W-1:0] jfld
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc  = instr[WORD_W-1 -: OPC_W];
  assign fn   = instr[FN_W-1:0];
  assign imm  = instr[IMM_W-1:0];
  assign jfld = instr[JFLD_W-1:0];

  always_comb begin
    flow = FLOW_SEQ;
    unique case (opc)
      OPC_SPECIAL: flow = (fn == FN_REGJMP) ? FLOW_RET : FLOW_SEQ;
      OPC_JUMP:    flow = FLOW_JUMP;
      OPC_JLINK:   flow = FLOW_JLINK;
      OPC_BREQ:    flow = FLOW_BREQ;
      OPC_BRNE:    flow = FLOW_BRNE;
      default:     flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target
  import npc_pkg::*;
(
  input  logic [WORD_W-1:0] pc_cur,
  input  flow_e             flow,
  input  logic [IMM_W-1:0]  imm,
  input  logic [JFLD_W-1:0] jfld,
  input  logic [WORD_W-1:0] rs_val,
  input  logic [WORD_W-1:0] rt_val,
  output logic [WORD_W-1:0] pc_inc,
  output logic [WORD_W-1:0] pc_nxt
);
  logic [WORD_W-1:0] br_off;
  logic [WORD_W-1:0] br_tgt;
  logic [WORD_W-1:0] jmp_tgt;
  logic              ops_eq;

  assign pc_inc  = pc_cur + WORD_W'(4);
  assign br_off  = {{SEXT_W{imm[IMM_W-1]}}, imm, {SHIFT_W{1'b0}}};
  assign br_tgt  = pc_inc + br_off;
  assign jmp_tgt = {pc_inc[WORD_W-1 -: PAGE_W], jfld, {SHIFT_W{1'b0}}};
  assign ops_eq  = (rs_val == rt_val);

  always_comb begin
    pc_nxt = pc_inc;
    unique case (flow)
      FLOW_BREQ:  pc_nxt = ops_eq  ? br_tgt : pc_inc;
      FLOW_BRNE:  pc_nxt = !ops_eq ? br_tgt : pc_inc;
      FLOW_JUMP,
      FLOW_JLINK: pc_nxt = jmp_tgt;
      FLOW_RET:   pc_nxt = rs_val;
      default:    pc_nxt = pc_inc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_ADDR = 32'h0040_0000,
  parameter logic [RIDX_W-1:0] LINK_REG   = 5'd31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] rs_val,
  input  logic [WORD_W-1:0] rt_val,
  output logic [WORD_W-1:0] pc,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_addr,
  output logic [WORD_W-1:0] link_data
);
  logic              rst_sync_n;
  flow_e             flow;
  logic [IMM_W-1:0]  imm;
  logic [JFLD_W-1:0] jfld;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] pc_d;
  logic [WORD_W-1:0] pc_inc;
  logic [WORD_W-1:0] pc_nxt;
  logic              pc_en;

  npc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_decode u_decode (
    .instr (instr),
    .flow  (flow),
    .imm   (imm),
    .jfld  (jfld)
  );

  npc_target u_target (
    .pc_cur (pc_q),
    .flow   (flow),
    .imm    (imm),
    .jfld   (jfld),
    .rs_val (rs_val),
    .rt_val (rt_val),
    .pc_inc (pc_inc),
    .pc_nxt (pc_nxt)
  );

  assign pc_en = !stall;

  always_comb begin
    pc_d = pc_q;
    if (pc_en) pc_d = pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pc_q <= RESET_ADDR;
    else             pc_q <= pc_d;
  end

  assign pc        = pc_q;
  assign link_we   = rst_sync_n && pc_en && (flow == FLOW_JLINK);
  assign link_addr = LINK_REG;
  assign link_data = pc_inc;
endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
  parameter logic [4:0] LINK_REG = 5'd31
) (
  input logic        clk,
  input logic        rst_q_n,
  input logic        stall,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic        link_we,
  input logic [4:0]  link_addr,
  input logic [31:0] link_data
);
  logic [5:0] opc;
  logic [31:0] boff;
  assign opc  = instr[31:26];
  assign boff = {{14{instr[15]}}, instr[15:0], 2'b00};

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |=> pc == $past(pc));
  // R8
  stall_nolink_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    stall |-> !link_we);
  // R9
  link_opc_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    link_we |-> opc == 6'd3);
  // R6
  link_fields_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    link_we |-> (link_addr == LINK_REG) && (link_data == pc + 32'd4));
  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall && opc > 6'd5) |=> pc == $past(pc) + 32'd4);
  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall && opc == 6'd0 && instr[5:0] == 6'h08) |=> pc == $past(rs_val));
  // R3
  breq_taken_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall && opc == 6'd4 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4 + $past(boff));
  // R5
  jump_tgt_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stall && opc == 6'd2) |=> pc[27:0] == {$past(instr[25:0]), 2'b00});
endmodule

bind npc_unit npc_unit_chk #(.LINK_REG(LINK_REG)) u_npc_unit_chk (
  .clk       (clk),
  .rst_q_n   (rst_sync_n),
  .stall     (stall),
  .instr     (instr),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .pc        (pc),
  .link_we   (link_we),
  .link_addr (link_addr),
  .link_data (link_data)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  localparam logic [31:0] RST = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [31:0] instr, rs_val, rt_val;
  logic [31:0] pc;
  logic        link_we;
  logic [4:0]  link_addr;
  logic [31:0] link_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  npc_unit #(.RESET_ADDR(RST)) u_npc_unit (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_we(link_we),
    .link_addr(link_addr), .link_data(link_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] want, input string tag);
    n_run++;
    if (act !== want) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, want);
    end
  endtask

  function automatic logic [31:0] model_next(input logic [31:0] cur, input logic [31:0] ins,
                                             input logic [31:0] a, input logic [31:0] b);
    logic [31:0] inc;
    logic [31:0] off;
    inc = cur + 32'd4;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    case (ins[31:26])
      6'd0:    return (ins[5:0] == 6'h08) ? a : inc;
      6'd2,
      6'd3:    return {inc[31:28], ins[25:0], 2'b00};
      6'd4:    return (a == b) ? inc + off : inc;
      6'd5:    return (a != b) ? inc + off : inc;
      default: return inc;
    endcase
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic stl, input string tag);
    logic [31:0] want;
    logic        we_want;
    instr = ins; rs_val = a; rt_val = b; stall = stl;
    #1;
    we_want = !stl && (ins[31:26] == 6'd3);
    check({31'd0, link_we}, {31'd0, we_want}, {tag, "/R9 link_we"});
    if (we_want) begin
      check({27'd0, link_addr}, 32'd31, "R6 link_addr");
      check(link_data, exp_pc + 32'd4, "R6 link_data");
    end
    want = stl ? exp_pc : model_next(exp_pc, ins, a, b);
    @(posedge clk); #1;
    check(pc, want, tag);
    exp_pc = want;
    @(negedge clk);
  endtask

  task automatic set_pc(input logic [31:0] v);
    step({6'd0, 5'd1, 15'd0, 6'h08}, v, 32'd0, 1'b0, "R7 set");
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [7];
    logic [31:0] bases [3];
    imms  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0123, 16'hFF00};
    bases = '{32'h0000_8000, 32'h7FFF_FFF0, 32'hBFC0_0100};
    rst_n = 1'b0; stall = 1'b0; instr = {6'd3, 26'h0}; rs_val = 0; rt_val = 0;
    @(negedge clk); #1;
    check(pc, RST, "R1 in reset");
    check({31'd0, link_we}, 32'd0, "R1 link_we in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(pc, RST, "R1 after release");
    check({31'd0, link_we}, 32'd0, "R1 link_we sync");
    stall = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(pc, RST, "R1 settled");
    exp_pc = RST;
    @(negedge clk);

    // R2: unrecognised opcodes
    for (int op = 0; op < 64; op++) begin
      if (op != 0 && (op < 2 || op > 5))
        step({op[5:0], 26'h2AB_CDEF}, 32'h1111_2220, 32'h1111_2220, 1'b0, "R2 opcode");
    end
    // R2: opcode 0 with other function codes
    for (int f = 0; f < 64; f++) begin
      if (f != 8)
        step({6'd0, 5'd3, 5'd4, 5'd5, 5'd0, f[5:0]}, 32'h0BAD_0000, 32'd0, 1'b0, "R2 funct");
    end

    // R7 register jumps, R10 wrap
    set_pc(32'h1234_5678);
    step({6'd0, 5'd9, 15'd0, 6'h08}, 32'h0000_1000, 32'd5, 1'b0, "R7 jump");
    set_pc(32'hFFFF_FFFC);
    step({6'd40, 26'd0}, 32'd0, 32'd0, 1'b0, "R10 wrap to 0");
    set_pc(32'hFFFF_FFF8);
    step({6'd4, 10'd0, 16'h0004}, 32'd7, 32'd7, 1'b0, "R10 branch wrap");

    // R3 / R4 branches
    foreach (bases[bi]) begin
      foreach (imms[ii]) begin
        set_pc(bases[bi]);
        step({6'd4, 5'd1, 5'd2, imms[ii]}, 32'hA5A5_0001, 32'hA5A5_0001, 1'b0, "R3 eq taken");
        step({6'd4, 5'd1, 5'd2, imms[ii]}, 32'hA5A5_0001, 32'hA5A5_0003, 1'b0, "R3 ne not taken");
        step({6'd5, 5'd1, 5'd2, imms[ii]}, 32'h0000_0000, 32'h8000_0000, 1'b0, "R4 ne taken");
        step({6'd5, 5'd1, 5'd2, imms[ii]}, 32'h5555_5555, 32'h5555_5555, 1'b0, "R4 eq not taken");
      end
    end

    // R5 / R6 jumps from every region
    for (int nib = 0; nib < 16; nib++) begin
      set_pc({nib[3:0], 28'h000_0100});
      step({6'd2, 26'h3FF_FFFF & (26'h111_1111 * nib[25:0] + 26'h0AB)}, 32'd0, 32'd0, 1'b0, "R5 jump");
      step({6'd3, 26'h155_5554 ^ nib[25:0]}, 32'd0, 32'd0, 1'b0, "R6 link jump");
    end
    set_pc(32'h3FFF_FFFC);
    step({6'd2, 26'h000_0040}, 32'd0, 32'd0, 1'b0, "R10 region carry");
    set_pc(32'h7FFF_FFFC);
    step({6'd3, 26'h3FF_FFFF}, 32'd0, 32'd0, 1'b0, "R6 region carry");

    // R8 stall
    set_pc(32'h0000_4000);
    step({6'd3, 26'h000_1234}, 32'd0, 32'd0, 1'b1, "R8 stall link");
    step({6'd5, 10'd0, 16'h0010}, 32'd1, 32'd2, 1'b1, "R8 stall branch");
    step({6'd0, 5'd1, 15'd0, 6'h08}, 32'hDEAD_BEE0, 32'd0, 1'b1, "R8 stall reg jump");
    step({6'd12, 26'd0}, 32'd0, 32'd0, 1'b1, "R8 stall seq");
    step({6'd3, 26'h000_1234}, 32'd0, 32'd0, 1'b0, "R6 after stall");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule